// File: doc/BRIEF.md
# Block-Pattern Video Line Shifter

This block turns a short line pattern into a one-bit video stream. A scan line of 640 visible pixels is cut into 16 equal blocks of 40 pixels. Each block shows one bit of a 16-bit pattern. The most significant bit is shown in the leftmost block. A pixel-enable pulse comes from a clock divider on the system clock. With a 50 MHz clock and the default divide ratio of 2, one pixel lasts 40 ns and one block lasts 1600 ns.

Two storage stages feed the output. Software writes the next pattern into a holding stage through a one-cycle write strobe. The output stage shifts out the pattern it is showing now. At the end of every line the output stage takes the holding stage's content and raises an empty interrupt, so that software can write the pattern for the following line. If nothing was written in time, the next line is blank and a sticky underrun flag is set. A synchronous reset clears everything and holds the video low.

Top module: `blkvid_shifter`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `video_out`, `irq_empty` and `underrun` are all 0, and the line starts again at pixel 0 of block 0.
- R2: The pixel position advances once every `DIV` clock cycles. `video_out` can change only at a block boundary, so the spacing between any two changes is a whole multiple of `PIX_PER_BLK*DIV` cycles.
- R3: During block k of a line (k = 0 at the left), `video_out` equals bit `BLK_PER_LINE-1-k` of the pattern loaded for that line. The bits go out MSB first.
- R4: At the end of a line, if the holding stage is full, its pattern becomes the next line's pattern, the holding stage becomes empty, and `irq_empty` is 1 from the following cycle.
- R5: At the end of a line, if the holding stage is empty, the next line shows all zeros, `underrun` becomes 1, and `irq_empty` is 1.
- R6: A write (`wr_en`=1) stores `wr_data` in the holding stage and marks it full. `irq_empty` is 0 in the following cycle. A second write before the line ends replaces the first, so only the last pattern written is shown.
- R7: If a write lands in the same cycle as a line end, the line that starts shows the earlier holding content. The new pattern stays held for the line after that, and `irq_empty` stays 0.
- R8: Once `underrun` is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle write strobe for the holding stage |
| wr_data | input | BLK_PER_LINE | Line pattern; bit BLK_PER_LINE-1 is the leftmost block |
| video_out | output | 1 | Serial one-bit video |
| irq_empty | output | 1 | Holding stage has been consumed and may be refilled |
| underrun | output | 1 | Sticky flag: a line ended with the holding stage empty |

## Verification
Every result is registered, so each one is due one clock after the edge that causes it:
- A write shows on `irq_empty` one clock after the strobe.
- A new block value, or a new line pattern at the line end, shows on `video_out` one clock after the pixel-enable edge that closes the block.
- `underrun` rises one clock after a line end that finds the holding stage empty.

The bench drives inputs at the falling edge and updates its reference model with those inputs. It then waits for the next rising edge and compares at the following falling edge, so model and design are always compared over the same number of edges. For the collision case, the bench finds the line-end cycle from its own pixel count and places the write exactly there.

// File: rtl/blkvid_pkg.sv
package blkvid_pkg;

  // Width of a counter that must hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // True when a modulo-lim counter sits on its final value.
  function automatic logic at_last(input int unsigned cnt, input int unsigned lim);
    return cnt == (lim - 1);
  endfunction

  // Number of clock cycles one block occupies.
  function automatic int unsigned block_cycles(input int unsigned pix, input int unsigned div);
    return pix * div;
  endfunction

  // What the output stage does on a given cycle.
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_SHIFT   = 2'd1,
    OP_PATTERN = 2'd2,
    OP_BLANK   = 2'd3
  } out_op_e;

endpackage

// File: rtl/blkvid_pixdiv.sv
module blkvid_pixdiv #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  import blkvid_pkg::*;

  localparam int unsigned DW = cnt_width(DIV);

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      logic [DW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (at_last(int'(cnt_q), DIV)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick = at_last(int'(cnt_q), DIV);
    end
  endgenerate

endmodule

// File: rtl/blkvid_timing.sv
module blkvid_timing #(
  parameter int unsigned PIX_PER_BLK  = 40,
  parameter int unsigned BLK_PER_LINE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic blk_end,
  output logic line_end
);
  import blkvid_pkg::*;

  localparam int unsigned PW = cnt_width(PIX_PER_BLK);
  localparam int unsigned BW = cnt_width(BLK_PER_LINE);

  logic [PW-1:0] pix_q;
  logic [BW-1:0] blk_q;
  logic          pix_last;
  logic          blk_last;

  assign pix_last = at_last(int'(pix_q), PIX_PER_BLK);
  assign blk_last = at_last(int'(blk_q), BLK_PER_LINE);
  assign blk_end  = tick && pix_last;
  assign line_end = blk_end && blk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q <= '0;
      blk_q <= '0;
    end else if (tick) begin
      if (pix_last) begin
        pix_q <= '0;
        blk_q <= blk_last ? '0 : blk_q + 1'b1;
      end else begin
        pix_q <= pix_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/blkvid_hold.sv
module blkvid_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         consume,
  output logic [W-1:0] hold_q,
  output logic         full_q,
  output logic         irq_q
);

  // A write always wins over the line-end consume on the flags; the output
  // stage has already sampled the earlier content on that edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (wr_en) begin
      hold_q <= wr_data;
      full_q <= 1'b1;
      irq_q  <= 1'b0;
    end else if (consume) begin
      full_q <= 1'b0;
      irq_q  <= 1'b1;
    end
  end

endmodule

// File: rtl/blkvid_outstage.sv
module blkvid_outstage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         blk_end,
  input  logic         line_end,
  input  logic [W-1:0] hold_q,
  input  logic         hold_full,
  output logic         video,
  output logic         underrun_q
);
  import blkvid_pkg::*;

  logic [W-1:0] sh_q;
  out_op_e      op;

  always_comb begin
    if (line_end) begin
      op = hold_full ? OP_PATTERN : OP_BLANK;
    end else if (blk_end) begin
      op = OP_SHIFT;
    end else begin
      op = OP_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      underrun_q <= 1'b0;
    end else begin
      case (op)
        OP_SHIFT:   sh_q <= {sh_q[W-2:0], 1'b0};
        OP_PATTERN: sh_q <= hold_q;
        OP_BLANK: begin
          sh_q       <= '0;
          underrun_q <= 1'b1;
        end
        default:    sh_q <= sh_q;
      endcase
    end
  end

  assign video = sh_q[W-1];

endmodule

// File: rtl/blkvid_shifter.sv
module blkvid_shifter #(
  parameter int unsigned DIV          = 2,
  parameter int unsigned PIX_PER_BLK  = 40,
  parameter int unsigned BLK_PER_LINE = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [BLK_PER_LINE-1:0] wr_data,
  output logic                    video_out,
  output logic                    irq_empty,
  output logic                    underrun
);

  // Internal events brought out by name for the bound checker.
  logic                    pix_tick_w;
  logic                    blk_end_w;
  logic                    line_end_w;
  logic                    hold_full_w;
  logic [BLK_PER_LINE-1:0] hold_pat_w;

  blkvid_pixdiv #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (pix_tick_w)
  );

  blkvid_timing #(
    .PIX_PER_BLK  (PIX_PER_BLK),
    .BLK_PER_LINE (BLK_PER_LINE)
  ) u_timing (
    .clk      (clk),
    .rst      (rst),
    .tick     (pix_tick_w),
    .blk_end  (blk_end_w),
    .line_end (line_end_w)
  );

  blkvid_hold #(.W(BLK_PER_LINE)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .consume (line_end_w),
    .hold_q  (hold_pat_w),
    .full_q  (hold_full_w),
    .irq_q   (irq_empty)
  );

  blkvid_outstage #(.W(BLK_PER_LINE)) u_out (
    .clk        (clk),
    .rst        (rst),
    .blk_end    (blk_end_w),
    .line_end   (line_end_w),
    .hold_q     (hold_pat_w),
    .hold_full  (hold_full_w),
    .video      (video_out),
    .underrun_q (underrun)
  );

endmodule

// File: rtl/blkvid_shifter_chk.sv
module blkvid_shifter_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic video_out,
  input logic irq_empty,
  input logic underrun,
  input logic blk_end_w,
  input logic line_end_w,
  input logic hold_full_w
);

  logic rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) rst_seen <= 1'b1;
  end

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rst_seen && $fell(rst)) |-> (!video_out && !irq_empty && !underrun)); // R1

  AST_VIDEO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (rst_seen && !$past(rst) && !$past(blk_end_w)) |-> $stable(video_out)); // R2

  AST_LINE_END_IRQ: assert property (@(posedge clk) disable iff (rst)
    (rst_seen && line_end_w && !wr_en) |=> irq_empty); // R4

  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (rst_seen && !$past(rst) && $rose(underrun)) |-> $past(line_end_w && !hold_full_w)); // R5

  AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (rst_seen && wr_en) |=> (!irq_empty && hold_full_w)); // R6

  AST_COLLIDE_KEEPS_FULL: assert property (@(posedge clk) disable iff (rst)
    (rst_seen && wr_en && line_end_w) |=> (hold_full_w && !irq_empty)); // R7

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rst_seen && !$past(rst) && $past(underrun)) |-> underrun); // R8

endmodule

bind blkvid_shifter blkvid_shifter_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .video_out   (video_out),
  .irq_empty   (irq_empty),
  .underrun    (underrun),
  .blk_end_w   (blk_end_w),
  .line_end_w  (line_end_w),
  .hold_full_w (hold_full_w)
);

// File: tb/blkvid_shifter_tb.sv
`timescale 1ns/1ps
module blkvid_shifter_tb;

  localparam int DIV  = 2;
  localparam int PIX  = 40;
  localparam int BLK  = 16;
  localparam int LINE = PIX * BLK;
  localparam int BCYC = PIX * DIV;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [BLK-1:0] wr_data = '0;
  logic           video_out;
  logic           irq_empty;
  logic           underrun;

  always #2 clk = ~clk;

  blkvid_shifter #(.DIV(DIV), .PIX_PER_BLK(PIX), .BLK_PER_LINE(BLK)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .video_out (video_out),
    .irq_empty (irq_empty),
    .underrun  (underrun)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Behavioural reference model
  int             m_sub;
  int             m_pix;
  logic [BLK-1:0] m_line;
  logic [BLK-1:0] m_q[$];
  logic           m_irq;
  logic           m_under;
  int             cyc;
  int             last_change;
  logic           prev_video;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sub = 0; m_pix = 0; m_line = '0; m_q.delete();
    m_irq = 1'b0; m_under = 1'b0; last_change = -1; prev_video = 1'b0;
  endtask

  task automatic compare();
    logic exp_v;
    exp_v = m_line[BLK - 1 - (m_pix / PIX)];
    check("R3 video", video_out, exp_v);
    check("R4 irq_empty", irq_empty, m_irq);
    check("R5 underrun", underrun, m_under);
    if (video_out !== prev_video) begin
      if (last_change >= 0) begin
        checks++;
        if (((cyc - last_change) % BCYC) != 0) begin
          errors++;
          $display("FAIL R2 change spacing: actual %0d expected multiple of %0d",
                   cyc - last_change, BCYC);
        end
      end
      last_change = cyc;
      prev_video = video_out;
    end
  endtask

  // Called at a falling edge: drive inputs, advance the model, move one clock.
  task automatic step(input logic w, input logic [BLK-1:0] d);
    rst = 1'b0; wr_en = w; wr_data = d;
    if (m_sub == DIV - 1) begin
      m_sub = 0;
      m_pix = m_pix + 1;
      if (m_pix == LINE) begin
        m_pix = 0;
        m_irq = 1'b1;
        if (m_q.size() > 0) begin
          m_line = m_q.pop_front();
        end else begin
          m_line = '0;
          m_under = 1'b1;
        end
      end
    end else begin
      m_sub = m_sub + 1;
    end
    if (w) begin
      m_q.delete();
      m_q.push_back(d);
      m_irq = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    compare();
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1 video in reset", video_out, 1'b0);
      check("R1 irq in reset", irq_empty, 1'b0);
      check("R1 underrun in reset", underrun, 1'b0);
    end
    model_reset();
  endtask

  task automatic run_to_line_end(input logic w, input logic [BLK-1:0] d);
    while (!(m_sub == DIV - 1 && m_pix == LINE - 1)) step(1'b0, '0);
    step(w, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0);
  endtask

  initial begin
    cyc = 0;
    model_reset();
    @(negedge clk);
    do_reset(3);
    step(1'b0, '0);
    check("R1 video after reset", video_out, 1'b0);
    check("R1 irq after reset", irq_empty, 1'b0);

    // R4: pattern written during the first line is shown on the second
    idle(5);
    step(1'b1, 16'hA5C3);
    check("R6 irq low after write", irq_empty, 1'b0);
    run_to_line_end(1'b0, '0);
    check("R4 irq after load", irq_empty, 1'b1);
    check("R4 block 0 of A5C3", video_out, 1'b1);
    check("R4 no underrun", underrun, 1'b0);
    idle(BCYC);
    check("R3 block 1 of A5C3", video_out, 1'b0);

    // R6: overwrite before line end; only the last write is shown
    idle(300);
    step(1'b1, 16'h1234);
    idle(7);
    step(1'b1, 16'h8001);
    check("R6 irq low after overwrite", irq_empty, 1'b0);
    run_to_line_end(1'b0, '0);
    check("R6 shows last write block 0", video_out, 1'b1);
    idle(BCYC);
    check("R6 shows last write block 1", video_out, 1'b0);

    // R5: no write during a line
    run_to_line_end(1'b0, '0);
    check("R5 underrun set", underrun, 1'b1);
    check("R5 blank line", video_out, 1'b0);
    check("R5 irq set", irq_empty, 1'b1);

    // R8: sticky across further lines
    run_to_line_end(1'b0, '0);
    idle(50);
    check("R8 underrun sticky", underrun, 1'b1);

    // R1: reset in the middle of a line
    do_reset(2);
    step(1'b0, '0);
    check("R1 underrun cleared", underrun, 1'b0);
    check("R1 video cleared", video_out, 1'b0);

    // R7: write exactly on the line-end cycle
    idle(20);
    step(1'b1, 16'hF00F);
    run_to_line_end(1'b1, 16'h0FF0);
    check("R7 shows earlier pattern", video_out, 1'b1);
    check("R7 irq stays low", irq_empty, 1'b0);
    check("R7 no underrun", underrun, 1'b0);
    run_to_line_end(1'b0, '0);
    check("R7 new pattern next line block 0", video_out, 1'b0);
    check("R7 irq after next line", irq_empty, 1'b1);
    idle(4 * BCYC);
    check("R7 new pattern block 4", video_out, 1'b1);
    idle(10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 150000; w++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule